// File: doc/BRIEF.md
# SPI Frame Error Detector

This block watches the select (active low) and clock pins of a serial slave port. Each frame is 16 clocks long and the clock idles low. The block decides whether each frame was well formed and allowed. It samples the clock level at the moment select falls and again at the moment it rises, and it counts rising clock edges while select is low. When select rises, it also takes in three results from the neighbouring logic: a CRC-valid flag from an external checker, and the decoded command type (write or not) and target address. If any rule is broken, the frame is a SPI error.

When select rises, the block latches the status for the next response. This status is a 2-bit basic code plus a detail bit that marks a SPI error. The code comes from the device state at that moment: the end-of-initialisation flag, the self-test control field and an internal-fault input. The latched value is held until the next frame closes. An error is therefore reported in exactly one response unless the following frame is also bad. Select and clock are brought into the system clock domain through two-flop synchronisers, and all edge detection is done on the synchronised copies.

The controller has two states. `FS_IDLE` means select is high. It moves to `FS_FRAME` on a detected select fall (transition "open"). `FS_FRAME` counts clock rises and returns to `FS_IDLE` on a detected select rise (transition "close"). The status is evaluated and latched in the close cycle.

Top module: `spi_frame_err_det`

## Requirements
- R1: If the clock is high when select falls, the frame is a SPI error.
- R2: A frame is a SPI error unless exactly FRAME_EDGES (16) rising clock edges are seen while select is low; 15 or 17 edges are errors, and 16 is not.
- R3: If the clock is high when select rises, the frame is a SPI error.
- R4: If `crc_ok` is low when select rises, the frame is a SPI error.
- R5: With `end_init` high, a frame with `cmd_write` high and `cmd_addr` other than LOCK_ADDR (6'h2A) is a SPI error. A write to 6'h2A, any write while `end_init` is low, and any non-write are not errors on this ground.
- R6: On an error-free frame with `int_fault` low, the code is 2'b00 when `end_init` is low and `selftest_ctrl` is zero, 2'b01 when `end_init` is high and `selftest_ctrl` is zero, and 2'b10 whenever `selftest_ctrl` is nonzero, whatever `end_init` is.
- R7: A SPI error gives code 2'b11 with `rsp_spi_err` high. With no SPI error but `int_fault` high, the code is 2'b11 with `rsp_spi_err` low.
- R8: Status is latched only when select rises. Changes to `end_init`, `selftest_ctrl` or `int_fault` between frames leave the outputs unchanged.
- R9: The edge counter saturates at its all-ones value (63 by default), so 80 edges are an error rather than aliasing to 16.
- R10: After an error frame, the next clean frame clears `rsp_spi_err` and restores the mode code.
- R11: After reset, `rsp_status` is 2'b00 and `rsp_spi_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low (asynchronous) |
| sclk | input | 1 | Serial clock, idles low (asynchronous) |
| crc_ok | input | 1 | CRC check result for the frame, valid at select rise |
| cmd_write | input | 1 | Decoded command is a register write |
| cmd_addr | input | ADDR_W | Decoded target register address |
| end_init | input | 1 | Initialisation-finished flag |
| selftest_ctrl | input | ST_W | Self-test control field; nonzero means self-test |
| int_fault | input | 1 | Some internal error other than SPI is present |
| rsp_status | output | 2 | Basic status code for the next response |
| rsp_spi_err | output | 1 | Detail bit: the last frame was a SPI error |

## Verification
The bench targets each error source in isolation. A frame with the clock high at select fall still carries 16 counted edges. A frame with the clock high at select rise uses 15 edges plus the final rise. A detector that checked only the edge count would therefore miss both. Frames with 15, 17 and 80 edges probe the count rule: a counter that wrapped instead of saturating would accept the 80-edge frame. Write-lock cases cover the lock address, writes before initialisation and reads, so an inverted or missing address compare shows up. Hold tests change the mode inputs between frames, and the error-then-clean sequence checks that a sticky flag or a live (unlatched) status would be caught.

// File: rtl/spi_fed_pkg.sv
package spi_fed_pkg;

    typedef enum logic [0:0] {
        FS_IDLE  = 1'b0,
        FS_FRAME = 1'b1
    } fed_state_e;

    typedef enum logic [1:0] {
        BS_INIT     = 2'b00,
        BS_NORMAL   = 2'b01,
        BS_SELFTEST = 2'b10,
        BS_FAULT    = 2'b11
    } base_status_e;

    // one spare bit above the frame length so the counter can overshoot and saturate
    function automatic int cnt_width(input int edges);
        return $clog2(edges + 1) + 1;
    endfunction

endpackage

// File: rtl/spi_fed_sync.sv
module spi_fed_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_fed_edge_cnt.sv
module spi_fed_edge_cnt #(
    parameter int FRAME_EDGES = 16,
    parameter int CNT_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             exact
);

    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [CNT_W-1:0] CNT_TARGET = CNT_W'(FRAME_EDGES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign exact = (cnt == CNT_TARGET);

endmodule

// File: rtl/spi_fed_fsm.sv
module spi_fed_fsm
    import spi_fed_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_lvl,
    input  logic       sclk_lvl,
    output fed_state_e state,
    output logic       frame_start,
    output logic       frame_end,
    output logic       edge_inc,
    output logic       start_err
);

    fed_state_e state_q, state_d;
    logic       cs_prev, sclk_prev;
    logic       cs_fall, cs_rise, sclk_rise;

    assign cs_fall   = cs_prev & ~cs_lvl;
    assign cs_rise   = ~cs_prev & cs_lvl;
    assign sclk_rise = ~sclk_prev & sclk_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (cs_fall) state_d = FS_FRAME;
            FS_FRAME: if (cs_rise) state_d = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        frame_start = 1'b0;
        frame_end   = 1'b0;
        edge_inc    = 1'b0;
        unique case (state_q)
            FS_IDLE: begin
                frame_start = cs_fall;
            end
            FS_FRAME: begin
                edge_inc  = sclk_rise;
                frame_end = cs_rise;
            end
        endcase
    end

    // previous levels and clock level captured at select fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
            start_err <= 1'b0;
        end else begin
            cs_prev   <= cs_lvl;
            sclk_prev <= sclk_lvl;
            if (frame_start) start_err <= sclk_lvl;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/spi_fed_status.sv
module spi_fed_status
    import spi_fed_pkg::*;
#(
    parameter int              ADDR_W    = 6,
    parameter int              ST_W      = 4,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 6'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic              start_err,
    input  logic              sclk_lvl,
    input  logic              count_ok,
    input  logic              crc_ok,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              end_init,
    input  logic [ST_W-1:0]   selftest_ctrl,
    input  logic              int_fault,
    output logic [1:0]        rsp_status,
    output logic              rsp_spi_err
);

    logic         lock_viol, frame_err;
    base_status_e code_d, code_q;

    assign lock_viol = end_init & cmd_write & (cmd_addr != LOCK_ADDR);
    assign frame_err = start_err | sclk_lvl | ~count_ok | ~crc_ok | lock_viol;

    always_comb begin
        if (frame_err || int_fault)  code_d = BS_FAULT;
        else if (|selftest_ctrl)     code_d = BS_SELFTEST;
        else if (end_init)           code_d = BS_NORMAL;
        else                         code_d = BS_INIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q      <= BS_INIT;
            rsp_spi_err <= 1'b0;
        end else if (frame_end) begin
            code_q      <= code_d;
            rsp_spi_err <= frame_err;
        end
    end

    assign rsp_status = code_q;

endmodule

// File: rtl/spi_frame_err_det.sv
module spi_frame_err_det
    import spi_fed_pkg::*;
#(
    parameter int                FRAME_EDGES = 16,
    parameter int                ADDR_W      = 6,
    parameter int                ST_W        = 4,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] LOCK_ADDR   = 6'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              crc_ok,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              end_init,
    input  logic [ST_W-1:0]   selftest_ctrl,
    input  logic              int_fault,
    output logic [1:0]        rsp_status,
    output logic              rsp_spi_err
);

    localparam int CNT_W = cnt_width(FRAME_EDGES);

    logic             cs_lvl, sclk_lvl;
    logic             frame_start, frame_end, edge_inc, start_err, count_ok;
    logic [CNT_W-1:0] edge_cnt;
    fed_state_e       state;

    spi_fed_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_lvl)
    );

    spi_fed_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_lvl)
    );

    spi_fed_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .sclk_lvl(sclk_lvl),
        .state(state), .frame_start(frame_start), .frame_end(frame_end),
        .edge_inc(edge_inc), .start_err(start_err)
    );

    spi_fed_edge_cnt #(.FRAME_EDGES(FRAME_EDGES), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(frame_start), .inc(edge_inc),
        .cnt(edge_cnt), .exact(count_ok)
    );

    spi_fed_status #(.ADDR_W(ADDR_W), .ST_W(ST_W), .LOCK_ADDR(LOCK_ADDR)) u_status (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .start_err(start_err),
        .sclk_lvl(sclk_lvl), .count_ok(count_ok), .crc_ok(crc_ok),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .end_init(end_init),
        .selftest_ctrl(selftest_ctrl), .int_fault(int_fault),
        .rsp_status(rsp_status), .rsp_spi_err(rsp_spi_err)
    );

endmodule

// File: rtl/spi_fed_checker.sv
module spi_fed_checker #(
    parameter int                FRAME_EDGES = 16,
    parameter int                ADDR_W      = 6,
    parameter int                CNT_W       = 6,
    parameter logic [ADDR_W-1:0] LOCK_ADDR   = 6'h2A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              frame_end,
    input logic              start_err,
    input logic              sclk_lvl,
    input logic [CNT_W-1:0]  edge_cnt,
    input logic              crc_ok,
    input logic              cmd_write,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              end_init,
    input logic [1:0]        rsp_status,
    input logic              rsp_spi_err
);

    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [CNT_W-1:0] CNT_TARGET = CNT_W'(FRAME_EDGES);

    assert_start_clk_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && start_err) |=> (rsp_spi_err && rsp_status == 2'b11));

    assert_edge_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && edge_cnt != CNT_TARGET) |=> rsp_spi_err);

    assert_end_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && sclk_lvl) |=> rsp_spi_err);

    assert_crc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !crc_ok) |=> rsp_spi_err);

    assert_write_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && end_init && cmd_write && cmd_addr != LOCK_ADDR) |=> rsp_spi_err);

    assert_fault_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_spi_err |-> (rsp_status == 2'b11));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(rsp_status) && $stable(rsp_spi_err)));

    assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_cnt == CNT_MAX && !frame_start) |=> (edge_cnt == CNT_MAX));

    assert_clean_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !start_err && !sclk_lvl && edge_cnt == CNT_TARGET && crc_ok
         && !(end_init && cmd_write && cmd_addr != LOCK_ADDR)) |=> !rsp_spi_err);

endmodule

bind spi_frame_err_det spi_fed_checker #(
    .FRAME_EDGES(FRAME_EDGES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOCK_ADDR(LOCK_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .start_err(start_err), .sclk_lvl(sclk_lvl), .edge_cnt(edge_cnt),
    .crc_ok(crc_ok), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .end_init(end_init), .rsp_status(rsp_status), .rsp_spi_err(rsp_spi_err)
);

// File: tb/tb_spi_frame_err_det.sv
`timescale 1ns/1ps
module tb_spi_frame_err_det;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       crc_ok = 1'b1;
    logic       cmd_write = 1'b0;
    logic [5:0] cmd_addr = 6'h00;
    logic       end_init = 1'b0;
    logic [3:0] selftest_ctrl = 4'h0;
    logic       int_fault = 1'b0;
    logic [1:0] rsp_status;
    logic       rsp_spi_err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    spi_frame_err_det dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .crc_ok(crc_ok),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .end_init(end_init),
        .selftest_ctrl(selftest_ctrl), .int_fault(int_fault),
        .rsp_status(rsp_status), .rsp_spi_err(rsp_spi_err)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [1:0] es, input logic ee);
        n_checks++;
        if (rsp_status !== es || rsp_spi_err !== ee) begin
            n_fail++;
            $display("FAIL %s: actual status=%b err=%b, expected status=%b err=%b",
                     req, rsp_status, rsp_spi_err, es, ee);
        end
    endtask

    task automatic run_frame(input int n_edges, input bit hi_start, input bit hi_end,
                             input bit crc, input bit wr, input logic [5:0] addr);
        crc_ok = crc; cmd_write = wr; cmd_addr = addr;
        if (hi_start) begin sclk = 1'b1; idle(3); end
        cs_n = 1'b0; idle(3);
        if (hi_start) begin sclk = 1'b0; idle(3); end
        for (int i = 0; i < n_edges; i++) begin
            sclk = 1'b1; idle(3);
            sclk = 1'b0; idle(3);
        end
        if (hi_end) begin sclk = 1'b1; idle(3); end
        cs_n = 1'b1; idle(3);
        sclk = 1'b0; idle(6);
        crc_ok = 1'b1; cmd_write = 1'b0;
    endtask

    task automatic t_reset;
        check("R11 reset state", 2'b00, 1'b0);
    endtask

    task automatic t_modes;
        end_init = 1'b0; selftest_ctrl = 4'h0;
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R6 init code", 2'b00, 1'b0);
        run_frame(16, 0, 0, 1, 1, 6'h05);
        check("R5 write before end_init allowed", 2'b00, 1'b0);
        selftest_ctrl = 4'h6;
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R6 selftest over init", 2'b10, 1'b0);
        end_init = 1'b1;
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R6 selftest over normal", 2'b10, 1'b0);
        selftest_ctrl = 4'h0;
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R6 normal code", 2'b01, 1'b0);
    endtask

    task automatic t_start_high;
        run_frame(16, 1, 0, 1, 0, 6'h05);
        check("R1 clock high at select fall", 2'b11, 1'b1);
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R10 clean frame clears error", 2'b01, 1'b0);
    endtask

    task automatic t_count;
        run_frame(15, 0, 0, 1, 0, 6'h05);
        check("R2 15 edges", 2'b11, 1'b1);
        run_frame(17, 0, 0, 1, 0, 6'h05);
        check("R2 17 edges", 2'b11, 1'b1);
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R2 16 edges accepted", 2'b01, 1'b0);
    endtask

    task automatic t_end_high;
        run_frame(15, 0, 1, 1, 0, 6'h05);
        check("R3 clock high at select rise", 2'b11, 1'b1);
    endtask

    task automatic t_crc;
        run_frame(16, 0, 0, 0, 0, 6'h05);
        check("R4 crc mismatch", 2'b11, 1'b1);
    endtask

    task automatic t_lock;
        run_frame(16, 0, 0, 1, 1, 6'h05);
        check("R5 write after init to other reg", 2'b11, 1'b1);
        run_frame(16, 0, 0, 1, 1, 6'h2A);
        check("R5 write to lock reg allowed", 2'b01, 1'b0);
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R5 read after init allowed", 2'b01, 1'b0);
    endtask

    task automatic t_internal;
        int_fault = 1'b1;
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R7 internal fault code", 2'b11, 1'b0);
        int_fault = 1'b0;
        run_frame(16, 0, 0, 0, 0, 6'h05);
        check("R7 spi error code and detail", 2'b11, 1'b1);
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R10 recovery to normal", 2'b01, 1'b0);
    endtask

    task automatic t_hold;
        selftest_ctrl = 4'h9; idle(10);
        check("R8 selftest change held", 2'b01, 1'b0);
        int_fault = 1'b1; end_init = 1'b0; idle(10);
        check("R8 fault change held", 2'b01, 1'b0);
        int_fault = 1'b0; end_init = 1'b1;
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R8 latched at next close", 2'b10, 1'b0);
        selftest_ctrl = 4'h0;
        run_frame(16, 0, 0, 1, 0, 6'h05);
    endtask

    task automatic t_saturate;
        run_frame(80, 0, 0, 1, 0, 6'h05);
        check("R9 80 edges not aliased", 2'b11, 1'b1);
        run_frame(16, 0, 0, 1, 0, 6'h05);
        check("R10 clean after saturation", 2'b01, 1'b0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_modes();
        t_start_high();
        t_count();
        t_end_high();
        t_crc();
        t_lock();
        t_internal();
        t_hold();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule